// File: doc/BRIEF.md
# Segment Address Translator with Access Rights

This block maps a two-part logical address to a physical address. The two parts are a segment selector and an offset. Four segment descriptors are held on chip. Each descriptor records where its region starts in physical memory, how many bytes it spans, and which kinds of access it allows. Each request selects one descriptor. The offset is added to the descriptor's start address. In the same pass the offset is tested against the span and the access kind is tested against the rights.

Bounds violations and rights violations have separate flags. Trap logic can therefore tell a stray pointer from a store into code. A privileged configuration port loads descriptors one at a time. The response is registered, and a new request can be issued on every cycle.

Top module: `seg_xlate`

## Requirements
- R1: For a request with no fault, `rsp_pa` equals the descriptor start plus the zero-extended offset, taken modulo 2^24, and `rsp_pa_ok` is 1.
- R2: `rsp_bnd_flt` is set exactly when the offset is greater than or equal to the selected descriptor's span. An offset of span-1 is in bounds.
- R3: Access kind is encoded on `req_kind` as 00 read, 01 write and 10 fetch. These need `cfg_perm` bit 0, bit 1 and bit 2 respectively. Code 11 always raises `rsp_perm_flt`.
- R4: The two fault flags are evaluated independently, so both can be set for one request. When either flag is set, `rsp_pa_ok` is 0 and `rsp_pa` is zero.
- R5: A selector of 4 to 7 (the selector is 3 bits wide and only 4 segments exist) returns a bounds fault with the rights fault clear.
- R6: A descriptor is loaded only when `cfg_we` and `cfg_priv` are both 1. A write with `cfg_priv` at 0 leaves every descriptor unchanged.
- R7: Reset clears every descriptor to start 0, span 0 and no rights. It also clears all response outputs.
- R8: The response appears on the first clock edge after the request. `rsp_vld` follows `req_vld` delayed by one cycle, and back-to-back requests are accepted. A cycle without a request yields `rsp_vld` 0 with all flags and `rsp_pa` zero.
- R9: A request in the same cycle as a descriptor load uses the old descriptor. The new contents apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor load strobe |
| cfg_priv | input | 1 | Privilege qualifier for the load |
| cfg_idx | input | 3 | Descriptor number to load |
| cfg_base | input | 24 | Physical start address |
| cfg_limit | input | 20 | Span in bytes |
| cfg_perm | input | 3 | Rights: bit0 read, bit1 write, bit2 fetch |
| req_vld | input | 1 | Request strobe |
| req_seg | input | 3 | Segment selector |
| req_off | input | 20 | Offset within the segment |
| req_kind | input | 2 | Access kind |
| rsp_vld | output | 1 | Response strobe |
| rsp_pa | output | 24 | Physical address, zero on fault |
| rsp_pa_ok | output | 1 | Translation usable |
| rsp_bnd_flt | output | 1 | Offset outside span or selector out of range |
| rsp_perm_flt | output | 1 | Access kind not allowed |

## Verification
The checker watches a set of properties on every cycle:
- the one-cycle request-to-response timing;
- the quiet response on idle cycles;
- the rule that a fault excludes a usable address;
- the bounds decision against the live descriptor span;
- the out-of-range selector result;
- the reserved-kind fault;
- that the table holds steady without a privileged load.

Only the bench scenarios can show the following:
- the actual address arithmetic, including wraparound past the top of physical space;
- the rights matrix per access kind;
- that unprivileged loads leave observable behaviour unchanged;
- the ordering between a load and a request in the same cycle;
- the cleared state after a reset in mid-run.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  parameter int SEGX_OFF_W = 20;
  parameter int SEGX_PA_W  = 24;

  localparam int RIGHT_RD = 0;
  localparam int RIGHT_WR = 1;
  localparam int RIGHT_EX = 2;
  localparam int RIGHT_W  = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic [SEGX_PA_W-1:0]  base;
    logic [SEGX_OFF_W-1:0] limit;
    logic [RIGHT_W-1:0]    rights;
  } seg_desc_t;

  // start + offset, wrapping at the top of physical space
  function automatic logic [SEGX_PA_W-1:0] seg_phys(
    input logic [SEGX_PA_W-1:0]  base,
    input logic [SEGX_OFF_W-1:0] off
  );
    return base + SEGX_PA_W'(off);
  endfunction

  function automatic logic seg_in_span(
    input logic [SEGX_OFF_W-1:0] off,
    input logic [SEGX_OFF_W-1:0] limit
  );
    return off < limit;
  endfunction

  function automatic logic seg_kind_allowed(
    input logic [1:0]         kind,
    input logic [RIGHT_W-1:0] rights
  );
    logic ok;
    case (kind)
      ACC_READ:  ok = rights[RIGHT_RD];
      ACC_WRITE: ok = rights[RIGHT_WR];
      ACC_FETCH: ok = rights[RIGHT_EX];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_xlate_pkg::*;
#(
  parameter int SEG_CNT   = 4,
  parameter int SEG_IDX_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [SEG_IDX_W-1:0]          wr_idx,
  input  seg_desc_t                     wr_desc,
  output seg_desc_t [SEG_CNT-1:0]       tbl
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < SEG_CNT; i++) begin
        if (wr_idx == SEG_IDX_W'(i)) tbl[i] <= wr_desc;
      end
    end
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_CNT   = 4,
  parameter int SEG_IDX_W = 3
) (
  input  seg_desc_t [SEG_CNT-1:0]       tbl,
  input  logic [SEG_IDX_W-1:0]          seg,
  input  logic [SEGX_OFF_W-1:0]         off,
  input  logic [1:0]                    kind,
  output logic [SEGX_PA_W-1:0]          pa,
  output logic                          bnd_flt,
  output logic                          perm_flt
);
  seg_desc_t sel;
  logic      hit;

  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = 0; i < SEG_CNT; i++) begin
      if (seg == SEG_IDX_W'(i)) begin
        hit = 1'b1;
        sel = tbl[i];
      end
    end
  end

  assign bnd_flt  = !hit || !seg_in_span(off, sel.limit);
  assign perm_flt = hit && !seg_kind_allowed(kind, sel.rights);
  assign pa       = seg_phys(sel.base, off);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_CNT   = 4,
  parameter int SEG_IDX_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic                   cfg_priv,
  input  logic [SEG_IDX_W-1:0]   cfg_idx,
  input  logic [SEGX_PA_W-1:0]   cfg_base,
  input  logic [SEGX_OFF_W-1:0]  cfg_limit,
  input  logic [RIGHT_W-1:0]     cfg_perm,
  input  logic                   req_vld,
  input  logic [SEG_IDX_W-1:0]   req_seg,
  input  logic [SEGX_OFF_W-1:0]  req_off,
  input  logic [1:0]             req_kind,
  output logic                   rsp_vld,
  output logic [SEGX_PA_W-1:0]   rsp_pa,
  output logic                   rsp_pa_ok,
  output logic                   rsp_bnd_flt,
  output logic                   rsp_perm_flt
);
  seg_desc_t [SEG_CNT-1:0] seg_tbl;
  seg_desc_t               load_desc;
  logic                    load_go;
  logic [SEGX_PA_W-1:0]    chk_pa;
  logic                    chk_bnd;
  logic                    chk_perm;
  logic                    chk_clean;

  assign load_go   = cfg_we && cfg_priv;
  assign load_desc = '{base: cfg_base, limit: cfg_limit, rights: cfg_perm};

  seg_desc_table #(.SEG_CNT(SEG_CNT), .SEG_IDX_W(SEG_IDX_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (load_go),
    .wr_idx  (cfg_idx),
    .wr_desc (load_desc),
    .tbl     (seg_tbl)
  );

  seg_check #(.SEG_CNT(SEG_CNT), .SEG_IDX_W(SEG_IDX_W)) u_check (
    .tbl      (seg_tbl),
    .seg      (req_seg),
    .off      (req_off),
    .kind     (req_kind),
    .pa       (chk_pa),
    .bnd_flt  (chk_bnd),
    .perm_flt (chk_perm)
  );

  assign chk_clean = !chk_bnd && !chk_perm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld      <= 1'b0;
      rsp_pa       <= '0;
      rsp_pa_ok    <= 1'b0;
      rsp_bnd_flt  <= 1'b0;
      rsp_perm_flt <= 1'b0;
    end else begin
      rsp_vld      <= req_vld;
      rsp_pa       <= (req_vld && chk_clean) ? chk_pa : '0;
      rsp_pa_ok    <= req_vld && chk_clean;
      rsp_bnd_flt  <= req_vld && chk_bnd;
      rsp_perm_flt <= req_vld && chk_perm;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
  import seg_xlate_pkg::*;
#(
  parameter int SEG_CNT   = 4,
  parameter int SEG_IDX_W = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_we,
  input logic                    cfg_priv,
  input logic                    req_vld,
  input logic [SEG_IDX_W-1:0]    req_seg,
  input logic [SEGX_OFF_W-1:0]   req_off,
  input logic [1:0]              req_kind,
  input seg_desc_t [SEG_CNT-1:0] tbl,
  input logic                    rsp_vld,
  input logic [SEGX_PA_W-1:0]    rsp_pa,
  input logic                    rsp_pa_ok,
  input logic                    rsp_bnd_flt,
  input logic                    rsp_perm_flt
);
  logic                  sel_hit;
  logic [SEGX_OFF_W-1:0] sel_span;

  always_comb begin
    sel_hit  = 1'b0;
    sel_span = '0;
    for (int i = 0; i < SEG_CNT; i++) begin
      if (req_seg == SEG_IDX_W'(i)) begin
        sel_hit  = 1'b1;
        sel_span = tbl[i].limit;
      end
    end
  end

  p_ok_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pa_ok |-> (rsp_vld && !rsp_bnd_flt && !rsp_perm_flt));
  p_fault_pa_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_bnd_flt || rsp_perm_flt) |-> (!rsp_pa_ok && rsp_pa == '0));
  p_rsp_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> (!rsp_vld && !rsp_pa_ok && !rsp_bnd_flt && !rsp_perm_flt));
  p_oor_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !sel_hit) |=> (rsp_bnd_flt && !rsp_perm_flt));
  p_over_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && sel_hit && req_off >= sel_span) |=> rsp_bnd_flt);
  p_in_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && sel_hit && req_off < sel_span) |=> !rsp_bnd_flt);
  p_rsvd_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && sel_hit && req_kind == 2'b11) |=> rsp_perm_flt);
  p_tbl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_priv) |=> $stable(tbl));
endmodule

bind seg_xlate seg_xlate_chk #(.SEG_CNT(SEG_CNT), .SEG_IDX_W(SEG_IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .cfg_priv     (cfg_priv),
  .req_vld      (req_vld),
  .req_seg      (req_seg),
  .req_off      (req_off),
  .req_kind     (req_kind),
  .tbl          (seg_tbl),
  .rsp_vld      (rsp_vld),
  .rsp_pa       (rsp_pa),
  .rsp_pa_ok    (rsp_pa_ok),
  .rsp_bnd_flt  (rsp_bnd_flt),
  .rsp_perm_flt (rsp_perm_flt)
);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_priv = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [23:0] cfg_base = '0;
  logic [19:0] cfg_limit = '0;
  logic [2:0]  cfg_perm = '0;
  logic        req_vld = 1'b0;
  logic [2:0]  req_seg = '0;
  logic [19:0] req_off = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_vld, rsp_pa_ok, rsp_bnd_flt, rsp_perm_flt;
  logic [23:0] rsp_pa;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seg_xlate u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_perm(cfg_perm),
    .req_vld(req_vld), .req_seg(req_seg), .req_off(req_off), .req_kind(req_kind),
    .rsp_vld(rsp_vld), .rsp_pa(rsp_pa), .rsp_pa_ok(rsp_pa_ok),
    .rsp_bnd_flt(rsp_bnd_flt), .rsp_perm_flt(rsp_perm_flt)
  );

  typedef struct packed {
    logic [2:0]  seg;
    logic [19:0] off;
    logic [1:0]  kind;
    logic        bnd;
    logic        perm;
    logic [23:0] pa;
  } vec_t;

  // kinds: 0 read, 1 write, 2 fetch, 3 reserved
  localparam vec_t VECS [14] = '{
    '{3'd0, 20'h00100, 2'd2, 1'b0, 1'b0, 24'h100100},
    '{3'd0, 20'h00100, 2'd1, 1'b0, 1'b1, 24'h000000},
    '{3'd0, 20'h0FFFF, 2'd0, 1'b0, 1'b0, 24'h10FFFF},
    '{3'd0, 20'h10000, 2'd0, 1'b1, 1'b0, 24'h000000},
    '{3'd0, 20'h20000, 2'd1, 1'b1, 1'b1, 24'h000000},
    '{3'd1, 20'h01000, 2'd1, 1'b0, 1'b0, 24'h201000},
    '{3'd1, 20'h01000, 2'd2, 1'b0, 1'b1, 24'h000000},
    '{3'd2, 20'h03FFF, 2'd0, 1'b0, 1'b0, 24'h303FFF},
    '{3'd2, 20'h04000, 2'd1, 1'b1, 1'b0, 24'h000000},
    '{3'd3, 20'h02000, 2'd1, 1'b0, 1'b0, 24'h001000},
    '{3'd3, 20'h02000, 2'd0, 1'b0, 1'b1, 24'h000000},
    '{3'd1, 20'h00000, 2'd3, 1'b0, 1'b1, 24'h000000},
    '{3'd5, 20'h00000, 2'd0, 1'b1, 1'b0, 24'h000000},
    '{3'd7, 20'hFFFFF, 2'd2, 1'b1, 1'b0, 24'h000000}
  };

  function automatic logic [27:0] exp_rsp(input logic b, input logic p, input logic [23:0] pa);
    return {1'b1, !(b || p), b, p, pa};
  endfunction

  task automatic check(input string tag, input logic [27:0] act, input logic [27:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got vld/ok/bnd/perm/pa=%07h expected %07h", tag, act, exp);
    end
  endtask

  function automatic logic [27:0] rsp_now();
    return {rsp_vld, rsp_pa_ok, rsp_bnd_flt, rsp_perm_flt, rsp_pa};
  endfunction

  task automatic load(input logic priv, input logic [2:0] idx, input logic [23:0] b,
                      input logic [19:0] l, input logic [2:0] r);
    @(negedge clk);
    cfg_we = 1'b1; cfg_priv = priv; cfg_idx = idx;
    cfg_base = b; cfg_limit = l; cfg_perm = r;
    @(negedge clk);
    cfg_we = 1'b0; cfg_priv = 1'b0;
  endtask

  // drive a single request at a negedge, sample at the next negedge
  task automatic one_req(input string tag, input logic [2:0] s, input logic [19:0] o,
                         input logic [1:0] k, input logic [27:0] exp);
    req_vld = 1'b1; req_seg = s; req_off = o; req_kind = k;
    @(negedge clk);
    req_vld = 1'b0;
    check(tag, rsp_now(), exp);
  endtask

  function automatic string vec_tag(input vec_t v);
    if (v.seg > 3'd3) return "R5";
    if (v.bnd && v.perm) return "R4";
    if (v.bnd) return "R2";
    if (v.perm) return "R3";
    return "R1";
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: cleared outputs during reset
    check("R7 reset outputs", rsp_now(), 28'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: descriptor cleared -> span 0 and no rights
    one_req("R7 empty descriptor", 3'd0, 20'h0, 2'd0, exp_rsp(1'b1, 1'b1, 24'h0));
    // R8: idle cycle is quiet
    @(negedge clk);
    check("R8 idle", rsp_now(), 28'h0);

    // rights: bit0 read, bit1 write, bit2 fetch
    load(1'b1, 3'd0, 24'h100000, 20'h10000, 3'b101);
    load(1'b1, 3'd1, 24'h200000, 20'h08000, 3'b011);
    load(1'b1, 3'd2, 24'h300000, 20'h04000, 3'b011);
    load(1'b1, 3'd3, 24'hFFF000, 20'h20000, 3'b010);

    // back-to-back vector walk (R8 throughput)
    for (int i = 0; i <= 14; i++) begin
      @(negedge clk);
      if (i > 0)
        check(vec_tag(VECS[i-1]), rsp_now(),
              exp_rsp(VECS[i-1].bnd, VECS[i-1].perm, VECS[i-1].pa));
      if (i < 14) begin
        req_vld = 1'b1; req_seg = VECS[i].seg; req_off = VECS[i].off; req_kind = VECS[i].kind;
      end else begin
        req_vld = 1'b0;
      end
    end
    @(negedge clk);
    check("R8 idle after burst", rsp_now(), 28'h0);

    // R6: unprivileged load of segment 1 must be ignored
    load(1'b0, 3'd1, 24'h000000, 20'hFFFFF, 3'b111);
    one_req("R6 unpriv span", 3'd1, 20'h09000, 2'd0, exp_rsp(1'b1, 1'b0, 24'h0));
    one_req("R6 unpriv rights", 3'd1, 20'h00010, 2'd2, exp_rsp(1'b0, 1'b1, 24'h0));
    one_req("R6 unpriv base", 3'd1, 20'h00010, 2'd0, exp_rsp(1'b0, 1'b0, 24'h200010));

    // R9: load and request in the same cycle
    cfg_we = 1'b1; cfg_priv = 1'b1; cfg_idx = 3'd2;
    cfg_base = 24'h400000; cfg_limit = 20'h04000; cfg_perm = 3'b011;
    req_vld = 1'b1; req_seg = 3'd2; req_off = 20'h00010; req_kind = 2'd0;
    @(negedge clk);
    cfg_we = 1'b0; cfg_priv = 1'b0;
    check("R9 old descriptor", rsp_now(), exp_rsp(1'b0, 1'b0, 24'h300010));
    @(negedge clk);
    req_vld = 1'b0;
    check("R9 new descriptor", rsp_now(), exp_rsp(1'b0, 1'b0, 24'h400010));

    // R7: reset in mid-run clears table and outputs
    req_vld = 1'b1; req_seg = 3'd0; req_off = 20'h00100; req_kind = 2'd2;
    rst_n = 1'b0;
    @(negedge clk);
    req_vld = 1'b0;
    check("R7 mid-run reset outputs", rsp_now(), 28'h0);
    rst_n = 1'b1;
    @(negedge clk);
    one_req("R7 table cleared", 3'd0, 20'h00100, 2'd2, exp_rsp(1'b1, 1'b1, 24'h0));

    finish_run();
  end
endmodule